// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned WIDTH-bit dividend by an unsigned WIDTH-bit divisor and returns a WIDTH-bit quotient and a WIDTH-bit remainder. It works one iteration per clock. The remainder register holds still. At launch, the divisor is placed WIDTH bits to the left in a register of twice the operand width. On each step that register is compared with the running remainder, subtracted from it where it fits, and then moved one place right. The quotient collects one bit per step from its low end.

A caller presents both operands with a one-cycle `start_i` while the block is idle. The block raises `busy_o` for the whole run. It then gives a single-cycle `done_o` together with the results. The results stay on the output registers until the next run finishes. A zero divisor follows the same schedule: it raises `div_zero_o` with `done_o` and returns an all-ones quotient and the dividend as the remainder.

Top module: `divu_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A `start_i` seen at a rising edge while the block is idle captures both operands, and `busy_o` is high from the next cycle.
- R3: `done_o` goes high exactly WIDTH+1 rising edges after the edge that captured the operands, and `busy_o` stays high for those WIDTH+1 cycles.
- R4: `done_o` lasts exactly one cycle, and `busy_o` is low in that cycle.
- R5: For a nonzero divisor, the results at `done_o` satisfy dividend = quotient × divisor + remainder, with remainder < divisor.
- R6: For a zero divisor, `div_zero_o` is 1 with `done_o`, `quotient_o` is all ones and `remainder_o` equals the dividend. For a nonzero divisor, `div_zero_o` is 0.
- R7: `start_i` and operand changes while `busy_o` is high are ignored: the results reported belong to the operands captured at launch, and no extra `done_o` follows.
- R8: `quotient_o`, `remainder_o` and `div_zero_o` change only in a cycle where `done_o` is high.
- R9: During a run, the working remainder never grows from one step to the next.
- R10: A dividend smaller than the divisor gives quotient 0 and the dividend as remainder. A divisor of 1 gives the dividend as quotient and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle pulse with new results |
| quotient_o | output | WIDTH | Registered quotient |
| remainder_o | output | WIDTH | Registered remainder |
| div_zero_o | output | 1 | Zero divisor flag, updated with done_o |

## Verification
A wrong compare or subtract in one step leaves an error in the remainder. That error is still there when `done_o` rises, so the identity check on the results catches any such slip exactly WIDTH+1 cycles after launch. A miscounted iteration counter moves the `done_o` edge and shifts every quotient bit by a factor of two, so it shows up on the first division measured. A launch path that is not held off while busy shows as results that belong to the second operand set, or as a second `done_o` pulse.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divu_state_t;
endpackage

// File: rtl/divu_step.sv
// One restoring step: trial compare of the scaled divisor against the
// remainder, conditional subtract.
module divu_step #(
  parameter int W2 = 32
) (
  input  logic [W2-1:0] rem_i,
  input  logic [W2-1:0] dvsr_i,
  output logic          fit_o,
  output logic [W2-1:0] rem_o
);
  logic [W2:0] diff;

  always_comb begin
    diff  = {1'b0, rem_i} - {1'b0, dvsr_i};
    fit_o = ~diff[W2];
    rem_o = fit_o ? diff[W2-1:0] : rem_i;
  end
endmodule

// File: rtl/divu_ctrl.sv
// Sequencer: idle/run state, iteration counter, done pulse.
module divu_ctrl
  import divu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int ITERS = WIDTH + 1;
  localparam int CW    = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(ITERS - 1);

  divu_state_t   state;
  logic [CW-1:0] iter;

  assign load_o = (state == ST_IDLE) && start_i;
  assign step_o = (state == ST_RUN);
  assign last_o = step_o && (iter == LAST_IDX);
  assign busy_o = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      iter   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state <= ST_RUN;
        iter  <= '0;
      end else if (last_o) begin
        state <= ST_IDLE;
        iter  <= '0;
      end else if (step_o) begin
        iter <= iter + 1'b1;
      end
    end
  end

  // Independent run-length count for the latency check.
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (load_o)  run_len <= '0;
    else if (busy_o)  run_len <= run_len + 1'b1;
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (run_len == (CW+1)'(ITERS)));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_no_relaunch_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_o) |=> (busy_o && !done_o));
endmodule

// File: rtl/divu_datapath.sv
// Operand registers, shifting scaled divisor, stationary remainder,
// quotient shift register and registered results.
module divu_datapath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             done_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);
  localparam int W2 = 2 * WIDTH;

  logic [W2-1:0]    rem_q, dvsr_q, rem_nx;
  logic [WIDTH-1:0] quo_q, quo_nx;
  logic             fit, zero_q;
  logic [WIDTH-1:0] op_a_q, op_b_q;

  divu_step #(.W2(W2)) u_step (
    .rem_i (rem_q),
    .dvsr_i(dvsr_q),
    .fit_o (fit),
    .rem_o (rem_nx)
  );

  generate
    if (WIDTH > 1) begin : g_qshift
      assign quo_nx = {quo_q[WIDTH-2:0], fit};
    end else begin : g_qbit
      assign quo_nx = fit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      dvsr_q <= '0;
      quo_q  <= '0;
      zero_q <= 1'b0;
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (load_i) begin
      rem_q  <= {{WIDTH{1'b0}}, dividend_i};
      dvsr_q <= {divisor_i, {WIDTH{1'b0}}};
      quo_q  <= '0;
      zero_q <= (divisor_i == '0);
      op_a_q <= dividend_i;
      op_b_q <= divisor_i;
    end else if (step_i) begin
      rem_q  <= rem_nx;
      dvsr_q <= dvsr_q >> 1;
      quo_q  <= quo_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
    end else if (last_i) begin
      quotient_o  <= quo_nx;
      remainder_o <= rem_nx[WIDTH-1:0];
      div_zero_o  <= zero_q;
    end
  end

  assert_rem_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (rem_q <= $past(rem_q)));

  assert_identity_R5: assert property (@(posedge clk) disable iff (rst)
    (done_i && op_b_q != '0) |->
      (({{WIDTH{1'b0}}, quotient_o} * {{WIDTH{1'b0}}, op_b_q})
        + {{WIDTH{1'b0}}, remainder_o} == {{WIDTH{1'b0}}, op_a_q}));

  assert_rem_below_div_R5: assert property (@(posedge clk) disable iff (rst)
    (done_i && op_b_q != '0) |-> (remainder_o < op_b_q));

  assert_zero_div_R6: assert property (@(posedge clk) disable iff (rst)
    (done_i && op_b_q == '0) |->
      (div_zero_o && quotient_o == '1 && remainder_o == op_a_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_i |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

// File: rtl/divu_seq.sv
module divu_seq #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);
  logic load, step, last;

  divu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  divu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .step_i     (step),
    .last_i     (last),
    .done_i     (done_o),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o),
    .div_zero_o (div_zero_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!busy_o && !done_o && !div_zero_o &&
                    quotient_o == '0 && remainder_o == '0));
endmodule

// File: tb/divu_seq_test.sv
module divu_seq_test;
  localparam int W = 16;
  localparam int LAT = W + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  divu_seq #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o)
  );

  function automatic logic [W-1:0] exp_quo(logic [W-1:0] a, logic [W-1:0] b);
    return (b == '0) ? '1 : a / b;
  endfunction

  function automatic logic [W-1:0] exp_rem(logic [W-1:0] a, logic [W-1:0] b);
    return (b == '0) ? a : a % b;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Launch one division; optionally try a relaunch mid-run with other operands.
  task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, input string tag);
    int cyc;
    int extra_done;
    @(negedge clk);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after launch", busy_o, 1);
    cyc = 1;
    while (!done_o && cyc < 4 * LAT) begin
      if (poke && cyc == 5) begin
        dividend_i = ~a; divisor_i = b + 3; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check(cyc - 1 == LAT, "R3 latency", cyc - 1, LAT);
    check(busy_o == 1'b0, "R4 busy low at done", busy_o, 0);
    check(quotient_o == exp_quo(a, b), {tag, " quotient"}, quotient_o, exp_quo(a, b));
    check(remainder_o == exp_rem(a, b), {tag, " remainder"}, remainder_o, exp_rem(a, b));
    check(div_zero_o == (b == '0), "R6 zero flag", div_zero_o, (b == '0));
    @(negedge clk);
    check(done_o == 1'b0, "R4 single pulse", done_o, 0);
    extra_done = 0;
    if (poke) begin
      for (int i = 0; i < LAT + 2; i++) begin
        if (done_o || busy_o) extra_done++;
        @(negedge clk);
      end
      check(extra_done == 0, "R7 no extra run", extra_done, 0);
    end
    check(quotient_o == exp_quo(a, b), "R8 quotient held", quotient_o, exp_quo(a, b));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [W-1:0] ra, rb;
    seed = 32'h1d2c;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !div_zero_o, "R1 reset flags", busy_o, 0);
    check(quotient_o == '0 && remainder_o == '0, "R1 reset results", quotient_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && quotient_o == '0, "R1 after reset", busy_o, 0);

    divide(16'd78, 16'd21, 1'b0, "R5 basic");
    divide(16'd5, 16'd9, 1'b0, "R10 small dividend");
    divide(16'hBEEF, 16'd1, 1'b0, "R10 divisor one");
    divide(16'h1234, 16'd0, 1'b0, "R6 zero divisor");
    divide(16'd0, 16'd0, 1'b0, "R6 zero by zero");
    divide(16'hFFFF, 16'hFFFF, 1'b0, "R5 equal max");
    divide(16'hFFFF, 16'h8000, 1'b0, "R5 top bit divisor");
    divide(16'd0, 16'd7, 1'b0, "R10 zero dividend");
    divide(16'd1000, 16'd33, 1'b1, "R7 relaunch ignored");

    for (int n = 0; n < 200; n++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      if (n % 4 == 1) rb = rb >> ($urandom % W);
      divide(ra, rb, 1'b0, "R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule